// File: doc/BRIEF.md
# SPI Serial Memory Target with Hold

This block is the serial front end of a byte-wide memory that answers as an SPI target. A host frames each transaction by pulling chip select low. It then sends an opcode, a two-byte address and, for writes, data bytes on SI. Read data comes back on SO. The block drives a plain synchronous port to an external 8192-byte array (address, write data, write strobe, read data with one cycle of latency). All serial inputs are sampled by the block's own clock, which must run at least eight times faster than SCK.

Write data is collected in a 32-byte page buffer. After chip select rises, the buffer is copied into the array over the next 32 clocks. A hold input pauses the transfer mid-byte without losing its place. This lets the host serve other work and then carry on where it stopped.

Top module: `spi_mem_target`

## Requirements
- R1: Both idle clock levels work: SCK may rest low (mode 0) or high (mode 3) when chip select falls. SI is captured on each SCK rising edge, and SO moves to its next bit only on an SCK falling edge.
- R2: so_oe is 1 only while the target is selected, not held, and in the read data phase. Otherwise it is 0, including right after reset.
- R3: After reset the target ignores all traffic until it has seen cs_n high and then low. If cs_n is low when reset is released, that frame is ignored.
- R4: The first byte of a frame is the opcode, MSB first: 8'h03 reads and 8'h02 writes. Any other opcode makes the rest of the frame inert: no array write and SO is never driven.
- R5: The address follows as two bytes, high byte first, MSB first. Only the low 13 bits are used, so the top 3 bits of the high byte have no effect.
- R6: A read returns the addressed byte MSB first, then the following bytes in turn. The address wraps from 13'h1FFF to 13'h0000 and crosses page boundaries freely.
- R7: During a write, each complete data byte goes into the page slot given by address bits [4:0]. Those bits then increment and wrap within the 32-byte page, while bits [12:5] stay fixed. A later byte in the same slot replaces the earlier one.
- R8: The buffered bytes reach the array only if chip select rises after a whole number of data bytes, with at least one byte sent. A partial final byte discards the whole write. Slots that received no byte are left unchanged.
- R9: With SCK low, hold_n low pauses the target. While paused, SCK and SI activity is ignored and so_oe is 0.
- R10: With SCK low, hold_n high resumes the transfer at the same bit and phase. A change of hold_n while SCK is high only takes effect at the next SCK low, after that falling edge has been acted on.
- R11: While the buffer is being copied (32 clocks after chip select rises), a new chip-select falling edge is ignored and its whole frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| mem_addr | output | 13 | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe |
| mem_rdata | input | 8 | Array read data, valid one clock after mem_addr |

## Verification
A bit counter that drifts, or a hold that is released early, shows up within one byte. SO returns a shifted pattern, or a write lands at a neighbouring slot. A wrong phase shows within one frame: so_oe goes high on a write or on an unknown opcode, or stays low on a read. Faults in the page buffer or commit logic appear on mem_we and mem_addr within 32 clocks of chip select rising. These include lost, extra or misplaced strobes, and a commit after a partial byte. A failure to block during commit shows as a driven SO in a frame that should be inert.

// File: rtl/spi_mem_target.sv
module spi_mem_target #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_WRITE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata
);
  localparam int PAGE = 1 << PAGE_W;

  typedef enum logic [2:0] {P_OPC, P_ADH, P_ADL, P_RD, P_WR, P_SKIP} phase_t;

  logic cs_q, cs_q2, sck_q, sck_q2, si_q, hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 1'b0; cs_q2 <= 1'b0;
      sck_q <= 1'b0; sck_q2 <= 1'b0;
      si_q <= 1'b0; hold_q <= 1'b1;
    end else begin
      cs_q <= cs_n; cs_q2 <= cs_q;
      sck_q <= sck; sck_q2 <= sck_q;
      si_q <= si; hold_q <= hold_n;
    end

  wire cs_fall  = cs_q2 && !cs_q;
  wire cs_rise  = !cs_q2 && cs_q;
  wire sck_rise = !sck_q2 && sck_q;
  wire sck_fall = sck_q2 && !sck_q;

  logic active, held, committing;
  logic [2:0] bitcnt;
  logic [7:0] shreg, rd_byte, out_sr;
  logic [ADDR_W-1:0] addr;
  logic [PAGE-1:0] pvalid;
  logic [7:0] pbuf [PAGE];
  logic [PAGE_W-1:0] slot;
  logic fetch, fetch_q, is_wr, so_r;
  phase_t phase;

  wire start   = cs_fall && !committing;
  wire run     = active && !held && !cs_q;
  wire rise_ev = run && sck_rise;
  wire fall_ev = run && sck_fall;
  wire [7:0] byte_in = {shreg[6:0], si_q};
  wire byte_done = rise_ev && (bitcnt == 3'd7);
  wire wr_byte = byte_done && (phase == P_WR);
  wire [PAGE_W-1:0] wr_slot = addr[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) active <= 1'b0;
    else if (start) active <= 1'b1;
    else if (cs_rise) active <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= 1'b0;
    else if (!active || start) held <= 1'b0;
    else if (!sck_q) held <= !hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_OPC; bitcnt <= 3'd0; shreg <= 8'd0; addr <= '0;
      is_wr <= 1'b0; pvalid <= '0; fetch <= 1'b0; fetch_q <= 1'b0;
      rd_byte <= 8'd0; out_sr <= 8'd0; so_r <= 1'b0;
    end else begin
      fetch <= 1'b0;
      fetch_q <= fetch;
      if (fetch_q) rd_byte <= mem_rdata;
      if (start) begin
        phase <= P_OPC;
        bitcnt <= 3'd0;
        so_r <= 1'b0;
      end else if (rise_ev) begin
        shreg <= byte_in;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7)
          case (phase)
            P_OPC: begin
              is_wr <= (byte_in == OP_WRITE);
              phase <= (byte_in == OP_READ || byte_in == OP_WRITE) ? P_ADH : P_SKIP;
            end
            P_ADH: begin
              addr[ADDR_W-1:8] <= byte_in[ADDR_W-9:0];
              phase <= P_ADL;
            end
            P_ADL: begin
              addr[7:0] <= byte_in;
              if (is_wr) begin
                phase <= P_WR;
                pvalid <= '0;
              end else begin
                phase <= P_RD;
                fetch <= 1'b1;
              end
            end
            P_RD: begin
              addr <= addr + 1'b1;
              fetch <= 1'b1;
            end
            P_WR: begin
              pvalid[wr_slot] <= 1'b1;
              addr[PAGE_W-1:0] <= wr_slot + 1'b1;
            end
            default: ;
          endcase
      end else if (fall_ev && phase == P_RD) begin
        if (bitcnt == 3'd0) begin
          so_r <= rd_byte[7];
          out_sr <= {rd_byte[6:0], 1'b0};
        end else begin
          so_r <= out_sr[7];
          out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk)
    if (wr_byte) pbuf[wr_slot] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      committing <= 1'b0;
      slot <= '0;
    end else if (committing) begin
      slot <= slot + 1'b1;
      if (&slot) committing <= 1'b0;
    end else if (cs_rise && active && phase == P_WR && bitcnt == 3'd0 && |pvalid) begin
      committing <= 1'b1;
      slot <= '0;
    end

  assign so        = so_r;
  assign so_oe     = active && !held && phase == P_RD;
  assign mem_we    = committing && pvalid[slot];
  assign mem_wdata = pbuf[slot];
  assign mem_addr  = committing ? {addr[ADDR_W-1:PAGE_W], slot} : addr;

  assert_so_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && !$past(fall_ev)) |-> $stable(so_r));

  assert_hiz_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_q2) |-> !so_oe);

  assert_page_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase == P_WR) |=> (phase != P_WR || $stable(addr[ADDR_W-1:PAGE_W])));

  assert_commit_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(committing) |-> ($past(bitcnt) == 3'd0 && $past(phase) == P_WR));

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(held) && $past(active) && active) |-> ($stable(bitcnt) && $stable(phase) && $stable(shreg)));

  assert_we_outside_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !active);
endmodule

// File: tb/spi_mem_target_test.sv
module spi_mem_target_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] mem_rdata = 8'd0;
  wire so, so_oe, mem_we;
  wire [12:0] mem_addr;
  wire [7:0] mem_wdata;

  spi_mem_target uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

  always #4 clk = ~clk;

  logic [7:0] mem [int];
  int we_cnt = 0;
  int total = 0, bad = 0;
  bit finished = 0;
  bit mode3 = 0;
  logic [7:0] rxb;
  bit oe_all, oe_hold, oe_defer;

  function automatic logic [7:0] seed(int a);
    return a[7:0] ^ {a[12:8], 3'b000} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] rdm(int a);
    return mem.exists(a) ? mem[a] : seed(a);
  endfunction

  always @(posedge clk) begin
    mem_rdata <= rdm(int'(mem_addr));
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      we_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    mode3 = m3; sck = m3; tick(2);
    cs_n = 1'b0; tick(4);
  endtask

  task automatic desel();
    if (!mode3) sck = 1'b0;
    tick(4); cs_n = 1'b1; tick(40);
  endtask

  task automatic xfer(input logic [7:0] tx, input int hb = -1, input bit hhi = 0);
    oe_all = 1; oe_hold = 0; oe_defer = 1;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i];
      if (i == hb) begin
        hold_n = 1'b0; tick(4);
        if (so_oe) oe_hold = 1;
        repeat (2) begin
          sck = 1'b1; si = ~si; tick(3);
          if (so_oe) oe_hold = 1;
          sck = 1'b0; tick(3);
        end
        si = tx[i]; hold_n = 1'b1;
      end
      tick(4);
      rxb[i] = so;
      if (!so_oe) oe_all = 0;
      sck = 1'b1; tick(4);
      if (hhi && i - 1 == hb) begin
        hold_n = 1'b0; tick(4);
        if (!so_oe) oe_defer = 0;
      end
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sck = 1'b0; si = tx[i]; tick(4);
      sck = 1'b1; tick(4);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [15:0] a);
    xfer(op); xfer(a[15:8]); xfer(a[7:0]);
  endtask

  task automatic t_gate_after_reset();
    chk("R2 reset so_oe", so_oe, 0);
    cmd(8'h03, 16'h0020); xfer(8'h00);
    chk("R3 no frame without cs edge", oe_all, 0);
    xfer(8'h02);
    desel();
    chk("R3 no write without cs edge", we_cnt, 0);
  endtask

  task automatic t_read_mode0_wrap();
    sel(0);
    cmd(8'h03, 16'hFFFE);
    xfer(8'h00); chk("R5 R6 byte 1FFE", rxb, seed(13'h1FFE));
    chk("R2 so driven in read", oe_all, 1);
    xfer(8'h00); chk("R6 byte 1FFF", rxb, seed(13'h1FFF));
    xfer(8'h00); chk("R6 wrap to 0000", rxb, seed(0));
    xfer(8'h00); chk("R1 R6 byte 0001", rxb, seed(1));
    desel();
    chk("R2 hiz after deselect", so_oe, 0);
  endtask

  task automatic t_read_mode3();
    sel(1);
    cmd(8'h03, 16'h0123);
    xfer(8'h00); chk("R1 mode3 byte 0123", rxb, seed(16'h0123));
    xfer(8'h00); chk("R1 mode3 byte 0124", rxb, seed(16'h0124));
    desel();
  endtask

  task automatic t_write_wrap();
    int w0 = we_cnt;
    sel(0);
    cmd(8'h02, 16'h0A1E);
    xfer(8'h11); chk("R2 no so in write", oe_all, 0);
    xfer(8'h22); xfer(8'h33); xfer(8'h44);
    desel();
    chk("R7 slot 1E", rdm(16'h0A1E), 8'h11);
    chk("R7 slot 1F", rdm(16'h0A1F), 8'h22);
    chk("R7 wrap slot 00", rdm(16'h0A00), 8'h33);
    chk("R7 slot 01", rdm(16'h0A01), 8'h44);
    chk("R8 untouched slot 02", rdm(16'h0A02), seed(16'h0A02));
    chk("R8 strobe count", we_cnt - w0, 4);
    sel(1);
    cmd(8'h03, 16'h0A1F);
    xfer(8'h00); chk("R6 readback 0A1F", rxb, 8'h22);
    xfer(8'h00); chk("R6 crosses page 0A20", rxb, seed(16'h0A20));
    desel();
  endtask

  task automatic t_overwrite();
    sel(0);
    cmd(8'h02, 16'h0040);
    for (int k = 0; k < 34; k++) xfer(8'h80 + k[7:0]);
    desel();
    chk("R7 slot 0 overwritten", rdm(16'h0040), 8'hA0);
    chk("R7 slot 1 overwritten", rdm(16'h0041), 8'hA1);
    chk("R7 slot 2 kept", rdm(16'h0042), 8'h82);
    chk("R7 slot 31", rdm(16'h005F), 8'h9F);
  endtask

  task automatic t_abort();
    int w0 = we_cnt;
    sel(0);
    cmd(8'h02, 16'h0200);
    xfer(8'h55); xfer(8'h66); xbits(8'hFF, 3);
    desel();
    chk("R8 partial byte aborts", rdm(16'h0200), seed(16'h0200));
    chk("R8 no strobe on abort", we_cnt - w0, 0);
    sel(1);
    cmd(8'h02, 16'h0210);
    desel();
    chk("R8 no strobe without data", we_cnt - w0, 0);
  endtask

  task automatic t_bad_opcode();
    int w0 = we_cnt;
    sel(0);
    xfer(8'h05); xfer(8'h00); xfer(8'h30);
    xfer(8'h77); chk("R4 unknown opcode no so", oe_all, 0);
    desel();
    chk("R4 unknown opcode no write", we_cnt - w0, 0);
    chk("R4 addr 0030 untouched", rdm(16'h0030), seed(16'h0030));
  endtask

  task automatic t_hold();
    sel(0);
    cmd(8'h02, 16'h0300);
    xfer(8'hC3, 4); chk("R9 hold so hiz in write", oe_hold, 0);
    xfer(8'h3C, 0);
    desel();
    chk("R10 held write byte 0", rdm(16'h0300), 8'hC3);
    chk("R10 held write byte 1", rdm(16'h0301), 8'h3C);
    sel(0);
    cmd(8'h03, 16'h0300);
    xfer(8'h00, 5);
    chk("R9 so hiz while held", oe_hold, 0);
    chk("R10 read byte after resume", rxb, 8'hC3);
    xfer(8'h00, 2, 1);
    chk("R10 hold deferred while sck high", oe_defer, 1);
    chk("R9 hiz after deferred hold", oe_hold, 0);
    chk("R10 read after deferred hold", rxb, 8'h3C);
    desel();
  endtask

  task automatic t_commit_busy();
    sel(0);
    cmd(8'h02, 16'h0500);
    xfer(8'h5A);
    tick(4); cs_n = 1'b1; tick(3); cs_n = 1'b0; tick(4);
    cmd(8'h03, 16'h0500); xfer(8'h00);
    chk("R11 frame during commit ignored", oe_all, 0);
    desel();
    chk("R11 commit completes", rdm(16'h0500), 8'h5A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(10);
    t_gate_after_reset();
    t_read_mode0_wrap();
    t_read_mode3();
    t_write_wrap();
    t_overwrite();
    t_abort();
    t_bad_opcode();
    t_hold();
    t_commit_busy();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule